// File: doc/BRIEF.md
# Byte-Lane Controller for a 16-bit Asynchronous Static RAM

This block lets synchronous on-chip logic read and write an external 256K x 16 asynchronous static RAM. All of its control pins are active low. On the user side, a request/ready handshake carries an 18-bit word address, 16 bits of write data, a two-bit lane mask and a write flag. Read results come back through a data bus with a one-cycle valid strobe. On the memory side, the block drives the address, the chip select, the output gate, the write strobe and the two byte-lane strobes. The data bus is split into an output value, a driver enable and an input value, so that an external tristate pad can be attached.

Every phase length is a parameter counted in clock periods, so the same RTL can meet the memory's nanosecond minimums at any clock rate. All writes are write-strobe controlled, and the output gate stays high for the whole write. Each word is opened and closed by its byte-lane strobes. After a word finishes, a following write can be accepted while the write strobe stays low, which gives back-to-back writes without a turnaround.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While the chip select is high, the output gate, write strobe and both lane strobes are high and the data driver is off. After reset the block is in this state, with `reqReady` high and `rdValid` low.
- R2: An accepted read with a nonzero mask holds the chip select and output gate low and the write strobe high for READ_CYCLES cycles. During those cycles the data driver is off, and a lane strobe is low exactly when its mask bit is set. Mask bit 1 selects the upper strobe (data 15:8) and mask bit 0 selects the lower strobe (data 7:0).
- R3: In the cycle after the last read cycle, `rdValid` is high for one cycle and `rdData` holds the sampled word. Lanes whose mask bit is clear read as zero.
- R4: An accepted write with a nonzero mask first spends TURNAROUND_CYCLES cycles with the chip select low, the output gate, write strobe and lane strobes high, and the write data driven. Then the write strobe goes low together with the masked lane strobes for WE_PULSE_CYCLES cycles.
- R5: The output gate is never low while the write strobe is low or while the data driver is on.
- R6: A write word ends when its lane strobes rise while the write strobe is still low. If no write follows, the write strobe rises next with the data still driven for one more cycle. The driver is then released at least one cycle before the output gate can fall.
- R7: A write with a nonzero mask can be accepted in the cycle in which a word's lane strobes have just risen. The write strobe then stays low, address and data change while the lane strobes are high, and the lane strobes fall after DATA_SETUP_CYCLES cycles.
- R8: A request with an all-zero mask completes in its acceptance cycle and leaves every memory pin inactive. For a read, `rdValid` follows in the next cycle with zero data. A write with a zero mask changes no stored byte.
- R9: The memory address, and the write data while the driver is on, stay unchanged across consecutive cycles in which a lane strobe is low.
- R10: `reqReady` is high in the idle state. After a word ends it is high only for a write with a nonzero mask, so a read presented there waits until idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| rdValid | output | 1 | One-cycle read result strobe |
| rdData | output | 16 | Read result, unmasked lanes zero |
| memAddr | output | 18 | Memory address |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output gate, active low |
| memWeN | output | 1 | Write strobe, active low |
| memUbN | output | 1 | Upper lane strobe, active low |
| memLbN | output | 1 | Lower lane strobe, active low |
| memDqOut | output | 16 | Data to the pad |
| memDqOe | output | 1 | Pad driver enable |
| memDqIn | input | 16 | Data from the pad |

## Verification
The checker watches pin-level safety on every cycle. It checks the quiet state while the chip is deselected, that the output gate and the data driver never overlap, that the driver is released before the output gate falls, that the output gate is high and the data is driven before the write strobe falls, that a held-low write strobe keeps the chip selected and driven, and that address and data are stable under a low lane strobe. The exact phase lengths and the byte-merge result can only be shown by the directed scenarios, which use a lane-aware memory model. So can the zero-mask shortcuts and the back-to-back acceptance window, along with refusing a read at the end of a word.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WPULSE,
    ST_WEND,
    ST_WSETUP,
    ST_WREL,
    ST_READ
  } state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // latch the request fields
    logic ceOn;    // chip select active
    logic oeOn;    // output gate active
    logic weOn;    // write strobe active
    logic laneOn;  // masked lane strobes active
    logic drive;   // pad driver on
    logic cap;     // sample read data this cycle
    logic zeroRd;  // zero-mask read: return zero
  } strobe_t;

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int LANES             = 2,
  parameter int READ_CYCLES       = 2,
  parameter int WE_PULSE_CYCLES   = 2,
  parameter int TURNAROUND_CYCLES = 1,
  parameter int DATA_SETUP_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             reqReady,
  output strobe_t          ctl
);

  localparam int MAX_AB = (READ_CYCLES > WE_PULSE_CYCLES) ? READ_CYCLES : WE_PULSE_CYCLES;
  localparam int MAX_CD = (TURNAROUND_CYCLES > DATA_SETUP_CYCLES) ? TURNAROUND_CYCLES : DATA_SETUP_CYCLES;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(READ_CYCLES - 1);
  localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TURNAROUND_CYCLES - 1);
  localparam logic [CNT_W-1:0] SU_LAST = CNT_W'(DATA_SETUP_CYCLES - 1);

  state_t           state, nextState;
  logic [CNT_W-1:0] cnt;
  logic             maskAny;

  assign maskAny = |reqMask;

  always_comb begin
    nextState = state;
    reqReady  = 1'b0;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          if (!maskAny) begin
            ctl.cap    = !reqWrite;
            ctl.zeroRd = !reqWrite;
          end else begin
            ctl.load  = 1'b1;
            nextState = reqWrite ? ST_TURN : ST_READ;
          end
        end
      end
      ST_TURN: begin
        ctl.ceOn  = 1'b1;
        ctl.drive = 1'b1;
        if (cnt == TA_LAST) nextState = ST_WPULSE;
      end
      ST_WPULSE: begin
        ctl.ceOn   = 1'b1;
        ctl.weOn   = 1'b1;
        ctl.laneOn = 1'b1;
        ctl.drive  = 1'b1;
        if (cnt == WE_LAST) nextState = ST_WEND;
      end
      ST_WEND: begin
        ctl.ceOn  = 1'b1;
        ctl.weOn  = 1'b1;
        ctl.drive = 1'b1;
        reqReady  = reqWrite && maskAny;
        if (reqValid && reqWrite && maskAny) begin
          ctl.load  = 1'b1;
          nextState = ST_WSETUP;
        end else begin
          nextState = ST_WREL;
        end
      end
      ST_WSETUP: begin
        ctl.ceOn  = 1'b1;
        ctl.weOn  = 1'b1;
        ctl.drive = 1'b1;
        if (cnt == SU_LAST) nextState = ST_WPULSE;
      end
      ST_WREL: begin
        ctl.ceOn  = 1'b1;
        ctl.drive = 1'b1;
        nextState = ST_IDLE;
      end
      ST_READ: begin
        ctl.ceOn   = 1'b1;
        ctl.oeOn   = 1'b1;
        ctl.laneOn = 1'b1;
        if (cnt == RD_LAST) begin
          ctl.cap   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= (nextState != state) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  laneN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] capWord;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneN[g] = ~(ctl.laneOn & maskQ[g]);
    assign capWord[g*LANE_W +: LANE_W] =
      (maskQ[g] && !ctl.zeroRd) ? memDqIn[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      maskQ   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        maskQ <= reqMask;
      end
      rdValid <= ctl.cap;
      if (ctl.cap) rdData <= capWord;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign memCeN   = ~ctl.ceOn;
  assign memOeN   = ~ctl.oeOn;
  assign memWeN   = ~ctl.weOn;
  assign memDqOe  = ctl.drive;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W            = 18,
  parameter int DATA_W            = 16,
  parameter int READ_CYCLES       = 2,
  parameter int WE_PULSE_CYCLES   = 2,
  parameter int TURNAROUND_CYCLES = 1,
  parameter int DATA_SETUP_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int LANES = 2;

  strobe_t          ctl;
  logic [LANES-1:0] laneN;

  sram_lane_fsm #(
    .LANES            (LANES),
    .READ_CYCLES      (READ_CYCLES),
    .WE_PULSE_CYCLES  (WE_PULSE_CYCLES),
    .TURNAROUND_CYCLES(TURNAROUND_CYCLES),
    .DATA_SETUP_CYCLES(DATA_SETUP_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .reqReady(reqReady),
    .ctl     (ctl)
  );

  sram_lane_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .laneN   (laneN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  assign memUbN = laneN[1];
  assign memLbN = laneN[0];

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  logic laneLow;
  assign laneLow = !memUbN || !memLbN;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    memCeN |-> (memOeN && memWeN && memUbN && memLbN && !memDqOe));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memDqOe));

  a_r6_release_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memOeN) |-> $past(!memDqOe));

  a_r4_settle_before_we: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(memOeN) && $past(memDqOe) && $past(!memCeN)));

  a_r7_held_we_driven: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memDqOe && memOeN));

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (laneLow && $past(laneLow)) |-> $stable(memAddr));

  a_r9_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (laneLow && $past(laneLow) && memDqOe) |-> $stable(memDqOut));

  a_r3_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> memCeN);

endmodule

bind sram_lane_ctrl sram_lane_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdValid(rdValid), .memAddr(memAddr),
  .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memUbN(memUbN),
  .memLbN(memLbN), .memDqOut(memDqOut), .memDqOe(memDqOe)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int RDC = 2;
  localparam int WEC = 2;
  localparam int TAC = 1;
  localparam int SUC = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic [17:0] memAddr;
  logic        memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe;
  logic [15:0] memDqOut, memDqIn;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_lane_ctrl #(
    .READ_CYCLES(RDC), .WE_PULSE_CYCLES(WEC),
    .TURNAROUND_CYCLES(TAC), .DATA_SETUP_CYCLES(SUC)
  ) u_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memUbN(memUbN), .memLbN(memLbN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // Lane-aware memory model; undriven lanes return 8'hA5
  logic [15:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (!memCeN && !memWeN) begin
      if (!memUbN) mem[memAddr[7:0]][15:8] <= memDqOut[15:8];
      if (!memLbN) mem[memAddr[7:0]][7:0]  <= memDqOut[7:0];
    end
  end

  logic rdGate;
  assign rdGate = !memCeN && !memOeN && memWeN;
  assign memDqIn[15:8] = (rdGate && !memUbN) ? mem[memAddr[7:0]][15:8] : 8'hA5;
  assign memDqIn[7:0]  = (rdGate && !memLbN) ? mem[memAddr[7:0]][7:0]  : 8'hA5;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  // Issue a request; returns at the first falling edge after acceptance
  task automatic issue(logic wr, logic [17:0] a, logic [15:0] d, logic [1:0] m);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    #1;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Pins in the cycles that follow the pulse of a word
  task automatic finishWrite(string tag);
    chk({tag, " R6 lanes up, we low"}, {memWeN, memUbN, memLbN}, 3'b011);
    @(negedge clk);
    chk({tag, " R6 we up, hold drive"}, {memCeN, memWeN, memDqOe, memOeN}, 4'b0111);
    @(negedge clk);
    chk({tag, " R6 driver off idle"}, {memCeN, memDqOe, reqReady}, 3'b101);
  endtask

  task automatic pulseCheck(string tag, logic [17:0] a, logic [15:0] d, logic [1:0] m);
    for (int i = 0; i < WEC; i++) begin
      chk({tag, " R4 pulse pins"}, {memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe},
          {1'b0, 1'b1, 1'b0, ~m[1], ~m[0], 1'b1});
      chk({tag, " R4 pulse addr/data"}, {memAddr[13:0], memDqOut}, {a[13:0], d});
      @(negedge clk);
    end
  endtask

  task automatic doWrite(string tag, logic [17:0] a, logic [15:0] d, logic [1:0] m);
    issue(1'b1, a, d, m);
    for (int i = 0; i < TAC; i++) begin
      chk({tag, " R4 settle pins"}, {memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe},
          6'b011111);
      @(negedge clk);
    end
    pulseCheck(tag, a, d, m);
    finishWrite(tag);
  endtask

  task automatic doRead(string tag, logic [17:0] a, logic [1:0] m, logic [15:0] exp);
    issue(1'b0, a, 16'h0, m);
    for (int i = 0; i < RDC; i++) begin
      chk({tag, " R2 read pins"}, {memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe},
          {1'b0, 1'b0, 1'b1, ~m[1], ~m[0], 1'b0});
      chk({tag, " R2 read addr"}, memAddr, a);
      @(negedge clk);
    end
    chk({tag, " R3 valid"}, rdValid, 1'b1);
    chk({tag, " R3 data"}, rdData, exp);
    @(negedge clk);
    chk({tag, " R3 one-cycle"}, rdValid, 1'b0);
  endtask

  task automatic tReset();
    chk("R1 reset pins", {memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe}, 6'b111110);
    chk("R1 reset handshake", {reqReady, rdValid}, 2'b10);
  endtask

  task automatic tFullWord();
    doWrite("full", 18'h00010, 16'h1234, 2'b11);
    doRead("full", 18'h00010, 2'b11, 16'h1234);
  endtask

  task automatic tByteLanes();
    doWrite("upper", 18'h00010, 16'hABCD, 2'b10);
    doRead("upper merge", 18'h00010, 2'b11, 16'hAB34);
    doWrite("lower", 18'h3FFFF, 16'h5A66, 2'b01);
    doRead("lower only R3", 18'h3FFFF, 2'b01, 16'h0066);
    doRead("upper mask R3", 18'h00010, 2'b10, 16'hAB00);
  endtask

  task automatic tZeroMask();
    issue(1'b0, 18'h00010, 16'h0, 2'b00);
    chk("R8 zero read valid", {rdValid, rdData}, {1'b1, 16'h0000});
    chk("R8 zero read pins", {memCeN, memOeN, memUbN, memLbN}, 4'b1111);
    @(negedge clk);
    chk("R8 zero read one-cycle", rdValid, 1'b0);
    issue(1'b1, 18'h00010, 16'hFFFF, 2'b00);
    chk("R8 zero write pins", {memCeN, memWeN, memDqOe}, 3'b110);
    doRead("R8 zero write unchanged", 18'h00010, 2'b11, 16'hAB34);
  endtask

  task automatic tBackToBack();
    issue(1'b1, 18'h00020, 16'hC0DE, 2'b11);
    for (int i = 0; i < TAC; i++) @(negedge clk);
    pulseCheck("b2b first", 18'h00020, 16'hC0DE, 2'b11);
    chk("R7 end of word", {memWeN, memUbN, memLbN}, 3'b011);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00021;
    reqWdata = 16'hBEEF; reqMask = 2'b11;
    #1;
    chk("R7 ready at word end", reqReady, 1'b1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < SUC; i++) begin
      chk("R7 setup pins", {memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe}, 6'b010111);
      chk("R7 new addr/data", {memAddr, memDqOut}, {18'h00021, 16'hBEEF});
      @(negedge clk);
    end
    pulseCheck("b2b second R7", 18'h00021, 16'hBEEF, 2'b11);
    finishWrite("b2b");
    doRead("b2b first back", 18'h00020, 2'b11, 16'hC0DE);
    doRead("b2b second back", 18'h00021, 2'b11, 16'hBEEF);
  endtask

  task automatic tReadWaits();
    issue(1'b1, 18'h00030, 16'h7711, 2'b11);
    for (int i = 0; i < TAC + WEC; i++) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 18'h00030; reqMask = 2'b11;
    #1;
    chk("R10 read refused at word end", reqReady, 1'b0);
    @(negedge clk); #1;
    chk("R10 read refused in release", reqReady, 1'b0);
    @(negedge clk); #1;
    chk("R10 ready in idle", reqReady, 1'b1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < RDC; i++) @(negedge clk);
    chk("R10 waited read data R3", {rdValid, rdData}, {1'b1, 16'h7711});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFullWord();
    tByteLanes();
    tZeroMask();
    tBackToBack();
    tReadWaits();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired act=%h exp=%h", 1'b1, 1'b0);
    summary();
  end

endmodule